// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running calendar of a real-time clock and raises a wake-up alarm when the current time reaches a programmed minute. Four alarm registers hold BCD targets for minute, hour, day of month and weekday. Setting bit 7 in any one of them removes that field from the comparison, so a disabled field matches any calendar value. The comparison is made once per minute, on the one-second tick that carries the seconds value 00. Seconds are never compared with a target.

A match sets a sticky alarm flag in a control register. While both the flag and the alarm interrupt enable in that register are 1, an active-low, level-type interrupt output is held low. Software releases the interrupt in one of two ways: it clears the flag by writing 0 to the flag bit, or it masks the output by clearing the enable. The calendar counter and the host bus sit outside the block. The block sees the calendar as BCD inputs and the host as a simple register write and read port.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset the four alarm registers read 0x80 (every field disabled), the control register reads 0x00, and `alarm_irq_n` is high.
- R2: The alarm registers for minute, hour, day and weekday sit at addresses 0x9, 0xA, 0xB and 0xC and read back all 8 bits written. The control register sits at 0x1 and holds the flag at bit 3 and the enable at bit 1. Its other bits, and every unmapped address, read 0.
- R3: The flag is set by the clock edge that ends a cycle in which `sec_tick` is 1, `cal_sec` is 00 (bit 7 ignored), and every enabled field equals its target. Only the valid bits of each field are compared: 7 bits of minute, 6 of hour, 6 of day, 3 of weekday.
- R4: An alarm register with bit 7 set matches any calendar value for that field.
- R5: A tick with a non-zero seconds value never sets the flag. Calendar values without a tick never set the flag.
- R6: With all four fields disabled, the flag is never set.
- R7: The flag stays set until the control register is written with bit 3 = 0. Writing bit 3 = 1 leaves the flag unchanged.
- R8: When a match and a clearing write occur in the same cycle, the flag ends up set.
- R9: `alarm_irq_n` is low exactly while the flag and the enable are both 1. Clearing the enable releases the output while the flag stays set.
- R10: A difference in any enabled field prevents the flag from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second; the calendar inputs are valid in that cycle |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_day | input | 8 | Calendar day of month, BCD |
| cal_wday | input | 8 | Calendar weekday, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_irq_n | output | 1 | Active-low level interrupt |

## Verification
The match logic is driven with several kinds of calendar stimulus. A full match with stray upper bits on the weekday input shows that field masking works. A tick at a non-zero second, and a full match presented without any tick, show that only the rollover strobe arms the flag. A single wrong hour separates a true match from a partial one. A mismatching hour whose field is disabled, and a register set with every field disabled, separate the per-field override from the rule that a fully disabled alarm never fires. Writes to the control register with the flag bit at 1 and at 0 separate a sticky flag from one that any write clears. The same clearing write is also issued in the same cycle as a match, to test that the match wins. Toggling the enable while the flag is set separates masking of the output from clearing the flag.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 4;

    // register addresses; alarm fields are consecutive from the base
    localparam int ADDR_CTRL  = 1;
    localparam int ADDR_ALM0  = 9;

    // bit positions decoded by software
    localparam int FLAG_BIT   = 3;
    localparam int AIE_BIT    = 1;
    localparam int DIS_BIT    = 7;

    localparam logic [DATA_W-1:0] ALM_RESET = DATA_W'(1 << DIS_BIT);
    localparam logic [DATA_W-1:0] SEC_MASK  = DATA_W'(8'h7f);

    // field index: 0 minute, 1 hour, 2 day, 3 weekday
    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            0:       field_mask = DATA_W'(8'h7f);
            1, 2:    field_mask = DATA_W'(8'h3f);
            default: field_mask = DATA_W'(8'h07);
        endcase
    endfunction

    typedef struct packed {
        logic flag;
        logic aie;
    } ctl_t;
endpackage

// File: rtl/alm_regs.sv
module alm_regs #(
    parameter int DW = alm_pkg::DATA_W,
    parameter int AW = alm_pkg::ADDR_W,
    parameter int NF = alm_pkg::NUM_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [NF-1:0][DW-1:0] alm_o
);
    typedef struct packed {
        logic [NF-1:0][DW-1:0] alm;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NF; i++) begin
            if (wr_en && (addr == AW'(alm_pkg::ADDR_ALM0 + i))) begin
                regs_d.alm[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= {NF{alm_pkg::ALM_RESET}};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign alm_o = regs_q.alm;
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp #(
    parameter int DW = alm_pkg::DATA_W,
    parameter int NF = alm_pkg::NUM_FIELDS
) (
    input  logic [NF-1:0][DW-1:0] alm_i,
    input  logic [NF-1:0][DW-1:0] cal_i,
    input  logic [DW-1:0]         cal_sec_i,
    input  logic                  sec_tick_i,
    output logic [NF-1:0]         fld_on_o,
    output logic                  hit_o
);
    logic [NF-1:0] fld_ok;
    logic          rollover;

    for (genvar g = 0; g < NF; g++) begin : g_field
        localparam logic [DW-1:0] MSK = DW'(alm_pkg::field_mask(g));
        assign fld_on_o[g] = ~alm_i[g][alm_pkg::DIS_BIT];
        assign fld_ok[g]   = ~fld_on_o[g] | ((alm_i[g] & MSK) == (cal_i[g] & MSK));
    end

    always_comb begin
        rollover = sec_tick_i && ((cal_sec_i & DW'(alm_pkg::SEC_MASK)) == '0);
        hit_o    = rollover && (&fld_ok) && (|fld_on_o);
    end
endmodule

// File: rtl/alm_ctrl.sv
module alm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_flag,
    input  logic wr_aie,
    input  logic hit_i,
    output logic flag_o,
    output logic aie_o,
    output logic irq_n_o
);
    alm_pkg::ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.aie = wr_aie;
            if (!wr_flag) begin
                ctl_d.flag = 1'b0;
            end
        end
        // a match overrides a clear in the same cycle
        if (hit_i) begin
            ctl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flag_o  = ctl_q.flag;
    assign aie_o   = ctl_q.aie;
    assign irq_n_o = ~(ctl_q.flag & ctl_q.aie);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter int DW = alm_pkg::DATA_W,
    parameter int AW = alm_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [DW-1:0] cal_sec,
    input  logic [DW-1:0] cal_min,
    input  logic [DW-1:0] cal_hour,
    input  logic [DW-1:0] cal_day,
    input  logic [DW-1:0] cal_wday,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          alarm_irq_n
);
    localparam int NF = alm_pkg::NUM_FIELDS;

    logic [NF-1:0][DW-1:0] alm_q;
    logic [NF-1:0][DW-1:0] cal_vec;
    logic [NF-1:0]         fld_on;
    logic                  hit;
    logic                  ctl_wr;
    logic                  ctl_flag;
    logic                  ctl_aie;

    assign cal_vec = {cal_wday, cal_day, cal_hour, cal_min};
    assign ctl_wr  = reg_wr && (reg_addr == AW'(alm_pkg::ADDR_CTRL));

    alm_regs #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .alm_o (alm_q)
    );

    alm_cmp #(.DW(DW), .NF(NF)) u_cmp (
        .alm_i      (alm_q),
        .cal_i      (cal_vec),
        .cal_sec_i  (cal_sec),
        .sec_tick_i (sec_tick),
        .fld_on_o   (fld_on),
        .hit_o      (hit)
    );

    alm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .wr_flag (reg_wdata[alm_pkg::FLAG_BIT]),
        .wr_aie  (reg_wdata[alm_pkg::AIE_BIT]),
        .hit_i   (hit),
        .flag_o  (ctl_flag),
        .aie_o   (ctl_aie),
        .irq_n_o (alarm_irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(alm_pkg::ADDR_CTRL)) begin
            reg_rdata[alm_pkg::FLAG_BIT] = ctl_flag;
            reg_rdata[alm_pkg::AIE_BIT]  = ctl_aie;
        end
        for (int i = 0; i < NF; i++) begin
            if (reg_addr == AW'(alm_pkg::ADDR_ALM0 + i)) begin
                reg_rdata = alm_q[i];
            end
        end
    end
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
    parameter int DW = alm_pkg::DATA_W,
    parameter int NF = alm_pkg::NUM_FIELDS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic [DW-1:0] cal_sec,
    input logic          ctl_wr,
    input logic          wr_flag,
    input logic [NF-1:0] fld_on,
    input logic          hit,
    input logic          flag,
    input logic          aie,
    input logic          irq_n
);
    // R5: the flag only rises after a tick at second 00
    p_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sec_tick && ((cal_sec & 8'h7f) == 8'h00)));

    // R6: nothing enabled, nothing raised
    p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|fld_on) && !flag) |=> !flag);

    // R7: sticky until a clearing write
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctl_wr && !wr_flag)) |=> flag);

    // R7: a clearing write with no tick drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_flag && !sec_tick) |=> !flag);

    // R8: match beats clear
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_flag && hit) |=> flag);

    // R9: output low while flag and enable are both set
    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && aie) |-> !irq_n);

    // R9: enable off keeps the output released
    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !aie |-> irq_n);
endmodule

bind alarm_match_unit alm_checker #(.DW(DW), .NF(NF)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .cal_sec  (cal_sec),
    .ctl_wr   (ctl_wr),
    .wr_flag  (reg_wdata[alm_pkg::FLAG_BIT]),
    .fld_on   (fld_on),
    .hit      (hit),
    .flag     (ctl_flag),
    .aie      (ctl_aie),
    .irq_n    (alarm_irq_n)
);

// File: tb/sim_alarm_match_unit.sv
`timescale 1ns/1ps
module sim_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] cal_sec = 8'h00, cal_min = 8'h00, cal_hour = 8'h00;
    logic [7:0] cal_day = 8'h01, cal_wday = 8'h00;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       alarm_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alarm_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_day(cal_day), .cal_wday(cal_wday),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_irq_n(alarm_irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic expect_irq(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {7'd0, alarm_irq_n}, {7'd0, exp});
    endtask

    task automatic set_cal(input logic [7:0] s, m, h, d, w);
        cal_sec = s; cal_min = m; cal_hour = h; cal_day = d; cal_wday = w;
    endtask

    task automatic tick(input logic [7:0] s, m, h, d, w);
        @(negedge clk);
        set_cal(s, m, h, d, w);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic program_alarm(input logic [7:0] m, h, d, w);
        wr(4'h9, m); wr(4'hA, h); wr(4'hB, d); wr(4'hC, w);
    endtask

    task automatic t_reset;
        for (int i = 9; i <= 12; i++) expect_reg("R1 alarm reset", 4'(i), 8'h80);
        expect_reg("R1 ctrl reset", 4'h1, 8'h00);
        expect_irq("R1 irq reset", 1'b1);
    endtask

    task automatic t_regs;
        program_alarm(8'h45, 8'h23, 8'h31, 8'h86);
        expect_reg("R2 min readback", 4'h9, 8'h45);
        expect_reg("R2 hour readback", 4'hA, 8'h23);
        expect_reg("R2 day readback", 4'hB, 8'h31);
        expect_reg("R2 wday readback", 4'hC, 8'h86);
        wr(4'h1, 8'hFF);
        expect_reg("R2 ctrl only enable", 4'h1, 8'h02);
        expect_reg("R2 unmapped", 4'h5, 8'h00);
        wr(4'h1, 8'h00);
        expect_reg("R2 ctrl cleared", 4'h1, 8'h00);
    endtask

    task automatic t_match;
        program_alarm(8'h30, 8'h12, 8'h15, 8'h03);
        tick(8'h00, 8'h30, 8'h12, 8'h15, 8'h0B);   // extra weekday bit masked
        expect_reg("R3 full match sets flag", 4'h1, 8'h08);
        expect_irq("R9 enable off irq high", 1'b1);
        wr(4'h1, 8'h00);
        expect_reg("R7 clear by write", 4'h1, 8'h00);
    endtask

    task automatic t_seconds;
        tick(8'h01, 8'h30, 8'h12, 8'h15, 8'h03);
        expect_reg("R5 non-zero second", 4'h1, 8'h00);
        @(negedge clk);
        set_cal(8'h00, 8'h30, 8'h12, 8'h15, 8'h03);
        repeat (3) @(negedge clk);
        expect_reg("R5 no tick", 4'h1, 8'h00);
    endtask

    task automatic t_mismatch;
        tick(8'h00, 8'h30, 8'h13, 8'h15, 8'h03);
        expect_reg("R10 hour differs", 4'h1, 8'h00);
        tick(8'h00, 8'h31, 8'h12, 8'h15, 8'h03);
        expect_reg("R10 minute differs", 4'h1, 8'h00);
    endtask

    task automatic t_disable;
        wr(4'hA, 8'h92);
        tick(8'h00, 8'h30, 8'h07, 8'h15, 8'h03);
        expect_reg("R4 disabled hour ignored", 4'h1, 8'h08);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_all_off;
        program_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h00);
        tick(8'h00, 8'h59, 8'h23, 8'h31, 8'h06);
        expect_reg("R6 all disabled", 4'h1, 8'h00);
    endtask

    task automatic t_sticky;
        program_alarm(8'h05, 8'h80, 8'h80, 8'h80);
        tick(8'h00, 8'h05, 8'h09, 8'h02, 8'h01);
        expect_reg("R3 minute only match", 4'h1, 8'h08);
        wr(4'h1, 8'h08);
        repeat (4) @(negedge clk);
        expect_reg("R7 write one keeps flag", 4'h1, 8'h08);
        tick(8'h00, 8'h06, 8'h09, 8'h02, 8'h01);
        expect_reg("R7 later mismatch keeps flag", 4'h1, 8'h08);
        wr(4'h1, 8'h00);
        expect_reg("R7 write zero clears", 4'h1, 8'h00);
    endtask

    task automatic t_irq;
        wr(4'h1, 8'h02);
        expect_irq("R9 enable alone irq high", 1'b1);
        tick(8'h00, 8'h05, 8'h10, 8'h03, 8'h02);
        expect_irq("R9 irq low on flag", 1'b0);
        wr(4'h1, 8'h0A);
        expect_irq("R9 still low", 1'b0);
        wr(4'h1, 8'h08);
        expect_irq("R9 masked by enable", 1'b1);
        expect_reg("R9 flag kept while masked", 4'h1, 8'h08);
        wr(4'h1, 8'h0A);
        expect_irq("R9 unmask low again", 1'b0);
        wr(4'h1, 8'h02);
        expect_irq("R9 clear flag releases", 1'b1);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_priority;
        @(negedge clk);
        set_cal(8'h00, 8'h05, 8'h11, 8'h04, 8'h03);
        sec_tick = 1'b1;
        reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 8'h00;
        @(negedge clk);
        sec_tick = 1'b0; reg_wr = 1'b0;
        expect_reg("R8 match beats clear", 4'h1, 8'h08);
        wr(4'h1, 8'h00);
        expect_reg("R8 cleared after", 4'h1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_match();
        t_seconds();
        t_mismatch();
        t_disable();
        t_all_off();
        t_sticky();
        t_irq();
        t_priority();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule